// File: doc/BRIEF.md
# NAND Bus Timing Sequencer

This block turns single host accesses into timed NAND bus cycles. A host access names one of three windows: command, address or data. The block then drives the latch-enable lines to suit the window and strobes write-enable or read-enable. Each access passes through up to four phases, and each phase lasts a number of clock cycles taken from a timing register: setup, wait (the strobe is low), hold, and a bus-release phase in which the data bus is floated. A second timing register with the same layout can be selected for each access.

A control register holds several settings: the bank enable that drives chip enable, the 8/16-bit bus width, and a ready-wait option. When ready-wait is set, the end of the wait phase is stretched while the device reports busy. The register also holds two short delays. One is inserted before a read that follows a command write, the other before a read that follows an address write, so that read-enable never comes too soon after a latch cycle. A read captures the data bus on the last wait cycle. Every access ends with a one-cycle done pulse.

Top module: `nand_cycle_seq`

## Requirements
- R1: After reset, chip enable is high (inactive), both latch lines are low, both strobes are high, the data bus is not driven, and busy and done are low. Timing fields reset to setup 0, wait 6, hold 4, release 1, and both read delays reset to 1.
- R2: `reg_sel` picks a register on a write. 0 is control: bit 1 ready-wait, bit 2 bank enable, bit 4 bus width (1 = 16-bit), bits 12:9 command-to-read delay, bits 16:13 address-to-read delay. 1 is common timing and 2 is alternate timing, each laid out as [7:0] setup, [15:8] wait, [23:16] hold, [31:24] release. A write with `reg_sel` = 3 changes nothing.
- R3: `acc_win` 1 is the command window and raises `nand_cle`. `acc_win` 2 is the address window and raises `nand_ale`. 0 and 3 are data and raise neither. The latch line is high through the setup, wait and hold phases only.
- R4: `nand_ce_n` is the inverse of the bank-enable bit and follows a control write from the next cycle.
- R5: The phases run in the order setup, wait, hold, release. Each lasts its field's count, and a count of 0 skips that phase. The exception is wait, which lasts at least 1 cycle. `nand_we_n` (writes) or `nand_re_n` (reads) is low exactly during the wait phase.
- R6: With `acc_attr` = 1 the access uses the alternate timing register; otherwise it uses the common one. The choice is fixed when the access is accepted.
- R7: If ready-wait was set when the access was accepted, the last wait cycle repeats while `nand_rb_n` is 0. With ready-wait clear, `nand_rb_n` has no effect.
- R8: A read captures `nand_dq_in` at the end of its last wait cycle. The value appears on `acc_rdata` from the next cycle and is held until the next read capture.
- R9: `acc_busy` is high in every cycle from the one after acceptance to the end of the last phase. `acc_done` is high for exactly one cycle, the one right after the last phase, with `acc_busy` low.
- R10: `acc_req` is taken only while `acc_busy` is low. A request raised during a busy access is ignored.
- R11: The data bus value depends on the window and the width. Command and address cycles drive the low byte with the upper byte at 0. Data writes drive 16 bits in 16-bit mode and only the low byte in 8-bit mode. Reads in 8-bit mode return the upper byte as 0.
- R12: A read whose previous accepted access was a command write is preceded by the command-to-read delay in cycles. A read after an address write is preceded by the address-to-read delay. In both cases all bus lines stay idle during the delay, and a delay of 0 adds nothing. Other reads have no delay.
- R13: `nand_dq_oe` is high through setup, wait and hold of a write and is never high during a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| acc_req | input | 1 | Access request (taken when not busy) |
| acc_win | input | 2 | Window: 0 data, 1 command, 2 address, 3 data |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_attr | input | 1 | Select alternate timing register |
| acc_wdata | input | DQ_W | Write data |
| acc_busy | output | 1 | Access in progress |
| acc_done | output | 1 | One-cycle completion pulse |
| acc_rdata | output | DQ_W | Last captured read data |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | DQ_W | Data bus out |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | DQ_W | Data bus in |
| nand_rb_n | input | 1 | Device ready (1) / busy (0) |

## Verification
The sequencer is exercised with several kinds of access. Command, address and data accesses under the reset timing show which latch line is raised. Reads straight after a command write, after an address write and after another read show whether the right delay, or no delay, is inserted. Programmed timings with zero fields show phase skipping and the one-cycle minimum wait, and alternate-timing accesses interleaved with common ones show that the selection happens per access. Bus width and ready-wait are flipped against each other: a busy device with ready-wait on versus off shows stretching only where it belongs. Byte patterns with distinct upper and lower halves show the narrowing rules, and a bus input that changes every cycle pins the read capture to one exact cycle.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    localparam int TF_W  = 8;   // width of one timing count
    localparam int DLY_W = 4;   // width of one read delay

    typedef enum logic [1:0] {
        WIN_DATA = 2'd0,
        WIN_CMD  = 2'd1,
        WIN_ADDR = 2'd2,
        WIN_ALT  = 2'd3
    } win_e;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_DLY   = 3'd1,
        PH_SETUP = 3'd2,
        PH_WAIT  = 3'd3,
        PH_HOLD  = 3'd4,
        PH_HIZ   = 3'd5
    } phase_e;

    // packed so that a 32-bit register write maps straight onto the fields
    typedef struct packed {
        logic [TF_W-1:0] hiz;
        logic [TF_W-1:0] hold;
        logic [TF_W-1:0] wt;
        logic [TF_W-1:0] setup;
    } timing_t;

    typedef struct packed {
        logic [DLY_W-1:0] ale_dly;
        logic [DLY_W-1:0] cle_dly;
        logic             wide;
        logic             bank_en;
        logic             rdy_wait;
    } ctrl_t;

    typedef struct packed {
        phase_e          ph;
        logic [TF_W-1:0] cnt;
    } step_t;

    localparam timing_t TIM_RST = '{hiz: 8'd1, hold: 8'd4, wt: 8'd6, setup: 8'd0};
    localparam ctrl_t  CTRL_RST = '{ale_dly: 4'd1, cle_dly: 4'd1, wide: 1'b0,
                                    bank_en: 1'b0, rdy_wait: 1'b0};

endpackage

// File: rtl/nand_seq_regs.sv
module nand_seq_regs
    import nand_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output ctrl_t       ctrl,
    output timing_t     tim_com,
    output timing_t     tim_att
);
    localparam int B_RDYW = 1;
    localparam int B_EN   = 2;
    localparam int B_WIDE = 4;
    localparam int CL_LSB = 9;
    localparam int AL_LSB = CL_LSB + DLY_W;

    typedef struct packed {
        ctrl_t   c;
        timing_t t0;
        timing_t t1;
    } rf_s;

    rf_s rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        if (reg_wr) begin
            case (reg_sel)
                2'd0: begin
                    rf_d.c.rdy_wait = reg_wdata[B_RDYW];
                    rf_d.c.bank_en  = reg_wdata[B_EN];
                    rf_d.c.wide     = reg_wdata[B_WIDE];
                    rf_d.c.cle_dly  = reg_wdata[CL_LSB +: DLY_W];
                    rf_d.c.ale_dly  = reg_wdata[AL_LSB +: DLY_W];
                end
                2'd1:    rf_d.t0 = timing_t'(reg_wdata);
                2'd2:    rf_d.t1 = timing_t'(reg_wdata);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_q <= '{c: CTRL_RST, t0: TIM_RST, t1: TIM_RST};
        end else begin
            rf_q <= rf_d;
        end
    end

    assign ctrl    = rf_q.c;
    assign tim_com = rf_q.t0;
    assign tim_att = rf_q.t1;

endmodule

// File: rtl/nand_seq_engine.sv
module nand_seq_engine
    import nand_seq_pkg::*;
#(
    parameter int DQ_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wide,
    input  logic             cfg_rdyw,
    input  logic [DLY_W-1:0] cfg_cle_dly,
    input  logic [DLY_W-1:0] cfg_ale_dly,
    input  timing_t          tim_com,
    input  timing_t          tim_att,
    input  logic             acc_req,
    input  logic [1:0]       acc_win,
    input  logic             acc_write,
    input  logic             acc_attr,
    input  logic [DQ_W-1:0]  acc_wdata,
    input  logic             rb_n,
    input  logic [DQ_W-1:0]  dq_in,
    output logic             busy,
    output logic             done,
    output logic [DQ_W-1:0]  rdata,
    output logic             cle,
    output logic             ale,
    output logic             we_n,
    output logic             re_n,
    output logic [DQ_W-1:0]  dq_out,
    output logic             dq_oe
);
    localparam int LANE_W = DQ_W / 2;

    typedef struct packed {
        phase_e          ph;
        logic [TF_W-1:0] cnt;
        timing_t         tim;
        logic            wr;
        win_e            win;
        logic            wide;
        logic            rdyw;
        win_e            last;
        logic [DQ_W-1:0] wdat;
        logic [DQ_W-1:0] rdat;
        logic            done;
    } eng_s;

    eng_s s_d, s_q;

    function automatic logic [TF_W-1:0] wait_len(timing_t t);
        return (t.wt == '0) ? TF_W'(1) : t.wt;
    endfunction

    // first phase after any delay: setup when non-zero, else wait
    function automatic step_t enter_front(timing_t t);
        step_t r;
        if (t.setup != '0) begin
            r.ph = PH_SETUP; r.cnt = t.setup;
        end else begin
            r.ph = PH_WAIT;  r.cnt = wait_len(t);
        end
        return r;
    endfunction

    // phase after wait (from_wait=1) or after hold (from_wait=0)
    function automatic step_t enter_tail(timing_t t, logic from_wait);
        step_t r;
        if (from_wait && t.hold != '0) begin
            r.ph = PH_HOLD; r.cnt = t.hold;
        end else if (t.hiz != '0) begin
            r.ph = PH_HIZ;  r.cnt = t.hiz;
        end else begin
            r.ph = PH_IDLE; r.cnt = '0;
        end
        return r;
    endfunction

    win_e             win_in;
    timing_t          tsel;
    logic [DLY_W-1:0] dly;
    step_t            st;
    logic             at_end;

    assign win_in = win_e'(acc_win);
    assign at_end = (s_q.cnt == TF_W'(1));

    always_comb begin
        s_d    = s_q;
        tsel   = acc_attr ? tim_att : tim_com;
        dly    = '0;
        if (!acc_write && s_q.last == WIN_CMD)  dly = cfg_cle_dly;
        if (!acc_write && s_q.last == WIN_ADDR) dly = cfg_ale_dly;
        st.ph  = s_q.ph;
        st.cnt = s_q.cnt - TF_W'(1);

        case (s_q.ph)
            PH_IDLE: begin
                st.cnt = s_q.cnt;
                if (acc_req) begin
                    s_d.tim  = tsel;
                    s_d.wr   = acc_write;
                    s_d.win  = win_in;
                    s_d.wide = cfg_wide;
                    s_d.rdyw = cfg_rdyw;
                    s_d.last = (acc_write && (win_in == WIN_CMD || win_in == WIN_ADDR))
                               ? win_in : WIN_DATA;
                    if (win_in == WIN_CMD || win_in == WIN_ADDR || !cfg_wide)
                        s_d.wdat = {{(DQ_W-LANE_W){1'b0}}, acc_wdata[LANE_W-1:0]};
                    else
                        s_d.wdat = acc_wdata;
                    if (dly != '0) begin
                        st.ph  = PH_DLY;
                        st.cnt = TF_W'(dly);
                    end else begin
                        st = enter_front(tsel);
                    end
                end
            end
            PH_DLY:   if (at_end) st = enter_front(s_q.tim);
            PH_SETUP: if (at_end) begin
                st.ph  = PH_WAIT;
                st.cnt = wait_len(s_q.tim);
            end
            PH_WAIT:  if (at_end) begin
                if (s_q.rdyw && !rb_n) begin
                    st.cnt = s_q.cnt;
                end else begin
                    if (!s_q.wr)
                        s_d.rdat = s_q.wide ? dq_in
                                 : {{(DQ_W-LANE_W){1'b0}}, dq_in[LANE_W-1:0]};
                    st = enter_tail(s_q.tim, 1'b1);
                end
            end
            PH_HOLD:  if (at_end) st = enter_tail(s_q.tim, 1'b0);
            PH_HIZ:   if (at_end) begin
                st.ph  = PH_IDLE;
                st.cnt = '0;
            end
            default: begin
                st.ph  = PH_IDLE;
                st.cnt = '0;
            end
        endcase

        s_d.ph   = st.ph;
        s_d.cnt  = st.cnt;
        s_d.done = (s_q.ph != PH_IDLE) && (st.ph == PH_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    logic act;
    assign act    = (s_q.ph == PH_SETUP) || (s_q.ph == PH_WAIT) || (s_q.ph == PH_HOLD);
    assign cle    = act && (s_q.win == WIN_CMD);
    assign ale    = act && (s_q.win == WIN_ADDR);
    assign we_n   = !((s_q.ph == PH_WAIT) && s_q.wr);
    assign re_n   = !((s_q.ph == PH_WAIT) && !s_q.wr);
    assign dq_oe  = act && s_q.wr;
    assign dq_out = s_q.wdat;
    assign busy   = (s_q.ph != PH_IDLE);
    assign done   = s_q.done;
    assign rdata  = s_q.rdat;

endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
    import nand_seq_pkg::*;
#(
    parameter int DQ_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [1:0]      reg_sel,
    input  logic [31:0]     reg_wdata,
    input  logic            acc_req,
    input  logic [1:0]      acc_win,
    input  logic            acc_write,
    input  logic            acc_attr,
    input  logic [DQ_W-1:0] acc_wdata,
    output logic            acc_busy,
    output logic            acc_done,
    output logic [DQ_W-1:0] acc_rdata,
    output logic            nand_ce_n,
    output logic            nand_cle,
    output logic            nand_ale,
    output logic            nand_we_n,
    output logic            nand_re_n,
    output logic [DQ_W-1:0] nand_dq_out,
    output logic            nand_dq_oe,
    input  logic [DQ_W-1:0] nand_dq_in,
    input  logic            nand_rb_n
);
    ctrl_t   ctrl;
    timing_t tim_com;
    timing_t tim_att;

    nand_seq_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .ctrl      (ctrl),
        .tim_com   (tim_com),
        .tim_att   (tim_att)
    );

    nand_seq_engine #(.DQ_W(DQ_W)) u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wide    (ctrl.wide),
        .cfg_rdyw    (ctrl.rdy_wait),
        .cfg_cle_dly (ctrl.cle_dly),
        .cfg_ale_dly (ctrl.ale_dly),
        .tim_com     (tim_com),
        .tim_att     (tim_att),
        .acc_req     (acc_req),
        .acc_win     (acc_win),
        .acc_write   (acc_write),
        .acc_attr    (acc_attr),
        .acc_wdata   (acc_wdata),
        .rb_n        (nand_rb_n),
        .dq_in       (nand_dq_in),
        .busy        (acc_busy),
        .done        (acc_done),
        .rdata       (acc_rdata),
        .cle         (nand_cle),
        .ale         (nand_ale),
        .we_n        (nand_we_n),
        .re_n        (nand_re_n),
        .dq_out      (nand_dq_out),
        .dq_oe       (nand_dq_oe)
    );

    assign nand_ce_n = !ctrl.bank_en;

endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk #(
    parameter int DQ_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            reg_wr,
    input logic [1:0]      reg_sel,
    input logic [31:0]     reg_wdata,
    input logic            acc_busy,
    input logic            acc_done,
    input logic            nand_ce_n,
    input logic            nand_cle,
    input logic            nand_ale,
    input logic            nand_we_n,
    input logic            nand_re_n,
    input logic [DQ_W-1:0] nand_dq_out,
    input logic            nand_dq_oe
);
    AST_CE_TRACKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd0) |=> (nand_ce_n == !$past(reg_wdata[2]))); // R4

    AST_LATCH_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale)); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_busy |-> (nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_dq_oe)); // R3

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n)); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |=> !acc_done); // R9

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |-> (!acc_busy && $past(acc_busy))); // R9

    AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |-> nand_dq_oe); // R13

    AST_READ_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> !nand_dq_oe); // R13

    AST_LATCH_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (nand_dq_oe && (nand_cle || nand_ale)) |-> (nand_dq_out[DQ_W-1:DQ_W/2] == '0)); // R11

endmodule

bind nand_cycle_seq nand_seq_chk #(.DQ_W(DQ_W)) u_chk (.*);

// File: tb/tb_nand_cycle_seq.sv
module tb_nand_cycle_seq;
    localparam int DQ_W = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_wr = 1'b0;
    logic [1:0]      reg_sel = '0;
    logic [31:0]     reg_wdata = '0;
    logic            acc_req = 1'b0;
    logic [1:0]      acc_win = '0;
    logic            acc_write = 1'b0;
    logic            acc_attr = 1'b0;
    logic [DQ_W-1:0] acc_wdata = '0;
    logic            acc_busy, acc_done;
    logic [DQ_W-1:0] acc_rdata;
    logic            nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [DQ_W-1:0] nand_dq_out;
    logic [DQ_W-1:0] nand_dq_in = '0;
    logic            nand_rb_n = 1'b1;

    always #5 clk = ~clk;

    nand_cycle_seq #(.DQ_W(DQ_W)) dut (.*);

    // ---------------- reference model ----------------
    typedef struct {
        bit cle; bit ale; bit we_n; bit re_n; bit oe; bit lastw; bit smp;
    } ent_t;

    ent_t        q[$];
    int          checks = 0;
    int          fails  = 0;
    bit          finished = 0;
    bit          m_rdyw, m_en, m_wide;
    int          m_cdly, m_adly, m_last;
    int          m_tim[2][4];   // [sel][setup, wait, hold, hiz]
    bit          s_rdyw, s_wide;
    logic [15:0] s_dq, exp_rdata;
    bit          exp_done;
    int          cyc = 0;

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic void model_reset();
        q.delete();
        m_rdyw = 0; m_en = 0; m_wide = 0;
        m_cdly = 1; m_adly = 1; m_last = 0;
        for (int s = 0; s < 2; s++) begin
            m_tim[s][0] = 0; m_tim[s][1] = 6; m_tim[s][2] = 4; m_tim[s][3] = 1;
        end
        s_rdyw = 0; s_wide = 0; s_dq = '0; exp_rdata = '0; exp_done = 0;
    endfunction

    function automatic void model_write(int sel, logic [31:0] d);
        if (sel == 0) begin
            m_rdyw = d[1]; m_en = d[2]; m_wide = d[4];
            m_cdly = int'(d[12:9]); m_adly = int'(d[16:13]);
        end else if (sel == 1 || sel == 2) begin
            for (int f = 0; f < 4; f++) m_tim[sel-1][f] = int'(d[f*8 +: 8]);
        end
    endfunction

    function automatic void build(int win, bit wr, bit attr, logic [15:0] d);
        ent_t idle, e, w;
        int   a, dly, wl;
        a = attr ? 1 : 0;
        idle = '{cle:0, ale:0, we_n:1, re_n:1, oe:0, lastw:0, smp:0};
        dly = 0;
        if (!wr && m_last == 1) dly = m_cdly;
        if (!wr && m_last == 2) dly = m_adly;
        for (int i = 0; i < dly; i++) q.push_back(idle);
        e = idle; e.cle = (win == 1); e.ale = (win == 2); e.oe = wr;
        for (int i = 0; i < m_tim[a][0]; i++) q.push_back(e);
        wl = (m_tim[a][1] == 0) ? 1 : m_tim[a][1];
        for (int i = 0; i < wl; i++) begin
            w = e; w.we_n = !wr; w.re_n = wr;
            w.lastw = (i == wl - 1); w.smp = (i == wl - 1) && !wr;
            q.push_back(w);
        end
        for (int i = 0; i < m_tim[a][2]; i++) q.push_back(e);
        for (int i = 0; i < m_tim[a][3]; i++) q.push_back(idle);
        s_rdyw = m_rdyw; s_wide = m_wide;
        s_dq = (win == 1 || win == 2 || !m_wide) ? {8'h00, d[7:0]} : d;
        m_last = (wr && (win == 1 || win == 2)) ? win : 0;
    endfunction

    task automatic compare();
        ent_t e;
        e = '{cle:0, ale:0, we_n:1, re_n:1, oe:0, lastw:0, smp:0};
        if (q.size() != 0) e = q[0];
        check("R3",  "cle",    nand_cle,  e.cle);
        check("R3",  "ale",    nand_ale,  e.ale);
        check("R5",  "we_n",   nand_we_n, e.we_n);
        check("R5",  "re_n",   nand_re_n, e.re_n);
        check("R13", "dq_oe",  nand_dq_oe, e.oe);
        if (e.oe) check("R11", "dq_out", nand_dq_out, s_dq);
        check("R4",  "ce_n",   nand_ce_n, !m_en);
        check("R9",  "busy",   acc_busy,  q.size() != 0);
        check("R9",  "done",   acc_done,  exp_done);
        check("R8",  "rdata",  acc_rdata, exp_rdata);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            exp_done = 0;
            if (q.size() != 0) begin
                if (!(q[0].lastw && s_rdyw && !nand_rb_n)) begin
                    if (q[0].smp) exp_rdata = s_wide ? nand_dq_in : {8'h00, nand_dq_in[7:0]};
                    void'(q.pop_front());
                    if (q.size() == 0) exp_done = 1;
                end
            end else if (acc_req) begin
                build(int'(acc_win), acc_write, acc_attr, acc_wdata);
            end
            if (reg_wr) model_write(int'(reg_sel), reg_wdata);
        end
        #2;
        if (rst_n && !finished) compare();
    end

    // ---------------- stimulus ----------------
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            nand_dq_in = 16'hC35A ^ 16'(cyc * 257);
        end
    end

    task automatic reg_write(logic [1:0] sel, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic access(logic [1:0] win, bit wr, bit attr, logic [15:0] d, output int n);
        @(negedge clk);
        acc_req = 1; acc_win = win; acc_write = wr; acc_attr = attr; acc_wdata = d;
        @(negedge clk);
        acc_req = 0;
        n = 0;
        while (!acc_done) begin
            if (acc_busy) n++;
            @(negedge clk);
        end
        @(negedge clk);
        check("R9", "done one cycle", acc_done, 0);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            fails++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1", "ce_n", nand_ce_n, 1);
        check("R1", "cle/ale", {nand_cle, nand_ale}, 0);
        check("R1", "strobes", {nand_we_n, nand_re_n}, 2'b11);
        check("R1", "oe/busy/done", {nand_dq_oe, acc_busy, acc_done}, 0);

        reg_write(2'd0, (32'd1 << 2) | (32'd1 << 9) | (32'd1 << 13));
        check("R4", "ce_n after enable", nand_ce_n, 0);

        access(2'd1, 1, 0, 16'h0070, n);
        check("R1", "default timing cycles", n, 11);
        access(2'd0, 0, 0, 16'h0000, n);
        check("R12", "read after command", n, 12);
        access(2'd2, 1, 0, 16'h0035, n);
        check("R3", "address cycles", n, 11);
        access(2'd0, 0, 0, 16'h0000, n);
        check("R12", "read after address", n, 12);
        access(2'd0, 0, 0, 16'h0000, n);
        check("R12", "read after read", n, 11);
        access(2'd3, 1, 0, 16'hA5C3, n);
        check("R11", "narrow data write", n, 11);

        reg_write(2'd1, 32'h0000_0002);
        access(2'd0, 1, 0, 16'h1234, n);
        check("R2", "setup2 wait0 cycles", n, 3);
        reg_write(2'd2, 32'h0202_0301);
        access(2'd0, 1, 1, 16'h4321, n);
        check("R6", "alternate timing", n, 8);
        access(2'd0, 1, 0, 16'h4321, n);
        check("R6", "common timing kept", n, 3);

        reg_write(2'd0, (32'd1 << 1) | (32'd1 << 2) | (32'd1 << 4) | (32'd3 << 9));
        access(2'd1, 1, 0, 16'hBEEF, n);
        check("R11", "wide command", n, 3);
        access(2'd0, 0, 0, 16'h0000, n);
        check("R12", "delay 3 after command", n, 6);
        access(2'd0, 1, 0, 16'hBEEF, n);
        check("R11", "wide data write", n, 3);
        access(2'd2, 1, 0, 16'hCAFE, n);
        check("R11", "wide address", n, 3);
        access(2'd0, 0, 0, 16'h0000, n);
        check("R12", "zero delay after address", n, 3);

        @(negedge clk);
        nand_rb_n = 0;
        fork
            access(2'd0, 0, 0, 16'h55AA, n);
            begin repeat (7) @(negedge clk); nand_rb_n = 1; end
        join
        check("R7", "stretched wait", n, 6);

        reg_write(2'd0, (32'd1 << 2) | (32'd1 << 4));
        nand_rb_n = 0;
        access(2'd0, 1, 0, 16'h55AA, n);
        check("R7", "busy ignored without ready-wait", n, 3);
        nand_rb_n = 1;

        fork
            access(2'd2, 1, 0, 16'h0011, n);
            begin
                repeat (2) @(negedge clk);
                acc_req = 1; acc_win = 2'd1;
                @(negedge clk);
                acc_req = 0; acc_win = 2'd0;
            end
        join
        check("R10", "request during busy", n, 3);
        @(negedge clk);
        check("R10", "no access started", acc_busy, 0);

        reg_write(2'd3, 32'hFFFF_FFFF);
        access(2'd0, 1, 0, 16'h0F0F, n);
        check("R2", "select 3 ignored", n, 3);

        reg_write(2'd0, 32'h0000_0000);
        check("R4", "ce_n after disable", nand_ce_n, 1);
        access(2'd0, 0, 0, 16'h0000, n);
        check("R11", "narrow read", acc_rdata[15:8], 8'h00);

        repeat (3) @(negedge clk);
        finished = 1;
        summary();
        $finish;
    end

endmodule